// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block takes one power partition from off to running in a fixed, safe order. A one-cycle start strobe carries the index of the partition to bring up. The sequencer then holds that partition in reset and asks for its power, unless the partition already reports power. After power is acknowledged it enables the partition clock and waits a settle interval. It then releases the isolation clamp, waits a second settle interval of the same length, and finally lets the partition out of reset. A single-cycle completion strobe reports success.

Each handshake step (power, clock, clamp release) has an acknowledge input, a failure input and its own timeout. A failure or a timeout backs the partition out in reverse order: the clamp closes first, then the clock stops, then the power request is withdrawn. A single-cycle error strobe follows once the back-out has finished. The per-partition control outputs are level signals that keep their values between sequences. The settle interval is given in clock cycles, so an integrator sets it to cover roughly 10 to 20 µs at the clock rate in use.

Top module: `partition_powerup_seq`

## Requirements
- R1: After reset every partition is held in reset (`part_rst_o` all ones), `pwr_req_o`, `clk_en_o` and `unclamp_o` are all zero, and `done_o` and `err_o` are low.
- R2: A partition's reset is asserted at least one cycle before its power request rises, and starting a sequence closes that partition's clamp.
- R3: A partition's clock enable rises only while that partition's power is requested or already reported on, and while its clamp is closed.
- R4: Clamp release follows the clock acknowledge by SETTLE_CYC cycles. With every handshake acknowledged at once, `done_o` goes high 5+2·SETTLE_CYC clock edges after the edge that samples the start strobe.
- R5: Reset release follows clamp acknowledge by SETTLE_CYC cycles. A partition is never out of reset while its clamp is closed, and after success its reset is low and its power request, clock enable and clamp release are high.
- R6: If `pwr_state_i` shows the partition already on, the power request is not touched and `done_o` comes one cycle earlier, at 4+2·SETTLE_CYC edges.
- R7: A power failure withdraws the request, leaves the partition in reset and raises `err_o` 3 edges after start.
- R8: A clock failure turns the clock off and then the power off, and `err_o` rises 5 edges after start.
- R9: A clamp failure closes the clamp, then stops the clock, then withdraws power, and `err_o` rises 7+SETTLE_CYC edges after start.
- R10: A step with no acknowledge and no failure for HS_TIMEOUT cycles fails as in R7, R8 or R9. The `err_o` strobe then arrives at 2+HS_TIMEOUT, 4+HS_TIMEOUT or 6+SETTLE_CYC+HS_TIMEOUT edges after start.
- R11: A start strobe that arrives while a sequence runs is ignored: it gives no result and changes no partition's outputs.
- R12: `done_o` and `err_o` are single-cycle pulses and are never high together. A failure input takes priority over the acknowledge input of the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to power up a partition |
| part_idx_i | input | IDXW | Partition index, sampled with `start_i` |
| pwr_state_i | input | NUM_PART | Current power state per partition (1 = on) |
| pwr_ack_i | input | 1 | Power-on acknowledge |
| pwr_fail_i | input | 1 | Power-on failure |
| clk_ack_i | input | 1 | Clock running acknowledge |
| clk_fail_i | input | 1 | Clock enable failure |
| ucl_ack_i | input | 1 | Clamp released acknowledge |
| ucl_fail_i | input | 1 | Clamp release failure |
| part_rst_o | output | NUM_PART | Per-partition reset, 1 = held in reset |
| pwr_req_o | output | NUM_PART | Per-partition power request |
| clk_en_o | output | NUM_PART | Per-partition clock enable |
| unclamp_o | output | NUM_PART | Per-partition clamp release |
| done_o | output | 1 | One-cycle success strobe |
| err_o | output | 1 | One-cycle failure strobe, after the back-out |

## Verification
Every result of this block is one strobe whose arrival edge is fixed by the start edge, the settle length and the timeout. Success is due 5+2·SETTLE_CYC edges after start, or 4+2·SETTLE_CYC when power is already on. The error strobe is due 3 or 2+HS_TIMEOUT edges after start for a power fault, 5 or 4+HS_TIMEOUT for a clock fault, and 7+SETTLE_CYC or 6+SETTLE_CYC+HS_TIMEOUT for a clamp fault. The driver computes that edge number from the start edge and queues it with the expected strobe kind and the expected per-partition output vectors. The monitor samples on falling edges, compares the free-running edge count with the queued value the moment a strobe appears, and checks on the next falling edge that the strobe has dropped.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_PCHK,
    ST_PWAIT,
    ST_CWAIT,
    ST_SET1,
    ST_UWAIT,
    ST_SET2,
    ST_UNCLK,
    ST_UNPWR
  } pps_state_e;

  typedef struct packed {
    logic rst_set;
    logic rst_clr;
    logic pwr_set;
    logic pwr_clr;
    logic clk_set;
    logic clk_clr;
    logic ucl_set;
    logic ucl_clr;
  } pps_cmd_t;

endpackage

// File: rtl/pps_cycle_timer.sv
module pps_cycle_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pps_flag_bank.sv
module pps_flag_bank #(
  parameter int   N       = 8,
  parameter int   IW      = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx_i,
  input  logic          set_i,
  input  logic          clr_i,
  output logic [N-1:0]  q_o
);

  logic [N-1:0] q_q, q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sel;
    assign sel = (idx_i == IW'(i));

    always_comb begin
      q_d[i] = q_q[i];
      if (sel && set_i) q_d[i] = 1'b1;
      if (sel && clr_i) q_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q[i] <= RST_VAL;
      else        q_q[i] <= q_d[i];
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int NUM_PART   = 8,
  parameter int IDXW       = 3,
  parameter int SETTLE_CYC = 12,
  parameter int HS_TIMEOUT = 20,
  parameter int CW         = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [IDXW-1:0]     part_idx_i,
  input  logic [NUM_PART-1:0] pwr_state_i,
  input  logic                pwr_ack_i,
  input  logic                pwr_fail_i,
  input  logic                clk_ack_i,
  input  logic                clk_fail_i,
  input  logic                ucl_ack_i,
  input  logic                ucl_fail_i,
  input  logic [CW-1:0]       cnt_i,
  output logic                clr_o,
  output pps_cmd_t            cmd_o,
  output logic [IDXW-1:0]     idx_o,
  output logic                done_o,
  output logic                err_o
);

  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(HS_TIMEOUT - 1);

  pps_state_e      state_q, state_d;
  logic [IDXW-1:0] idx_q;
  logic            idx_en;
  logic            done_q, done_d, err_q, err_d;
  logic            already_on;
  logic            settle_end, tmo;

  always_comb begin
    already_on = 1'b0;
    for (int i = 0; i < NUM_PART; i++)
      if (idx_q == IDXW'(i)) already_on = pwr_state_i[i];
  end

  assign settle_end = (cnt_i == SET_LAST);
  assign tmo        = (cnt_i == TMO_LAST);

  always_comb begin
    state_d = state_q;
    cmd_o   = '0;
    idx_en  = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        idx_en  = 1'b1;
        state_d = ST_RST;
      end
      ST_RST: begin
        cmd_o.rst_set = 1'b1;
        cmd_o.ucl_clr = 1'b1;
        state_d       = ST_PCHK;
      end
      ST_PCHK: begin
        if (already_on) begin
          cmd_o.clk_set = 1'b1;
          state_d       = ST_CWAIT;
        end else begin
          cmd_o.pwr_set = 1'b1;
          state_d       = ST_PWAIT;
        end
      end
      ST_PWAIT: begin
        if (pwr_fail_i || (!pwr_ack_i && tmo)) begin
          cmd_o.pwr_clr = 1'b1;
          err_d         = 1'b1;
          state_d       = ST_IDLE;
        end else if (pwr_ack_i) begin
          cmd_o.clk_set = 1'b1;
          state_d       = ST_CWAIT;
        end
      end
      ST_CWAIT: begin
        if (clk_fail_i || (!clk_ack_i && tmo)) begin
          cmd_o.clk_clr = 1'b1;
          state_d       = ST_UNPWR;
        end else if (clk_ack_i) begin
          state_d = ST_SET1;
        end
      end
      ST_SET1: if (settle_end) begin
        cmd_o.ucl_set = 1'b1;
        state_d       = ST_UWAIT;
      end
      ST_UWAIT: begin
        if (ucl_fail_i || (!ucl_ack_i && tmo)) begin
          cmd_o.ucl_clr = 1'b1;
          state_d       = ST_UNCLK;
        end else if (ucl_ack_i) begin
          state_d = ST_SET2;
        end
      end
      ST_SET2: if (settle_end) begin
        cmd_o.rst_clr = 1'b1;
        done_d        = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_UNCLK: begin
        cmd_o.clk_clr = 1'b1;
        state_d       = ST_UNPWR;
      end
      ST_UNPWR: begin
        cmd_o.pwr_clr = 1'b1;
        err_d         = 1'b1;
        state_d       = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign clr_o = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= part_idx_i;
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/partition_powerup_seq.sv
module partition_powerup_seq
  import pps_pkg::*;
#(
  parameter int NUM_PART   = 8,
  parameter int SETTLE_CYC = 12,
  parameter int HS_TIMEOUT = 20,
  localparam int IDXW      = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [IDXW-1:0]     part_idx_i,
  input  logic [NUM_PART-1:0] pwr_state_i,
  input  logic                pwr_ack_i,
  input  logic                pwr_fail_i,
  input  logic                clk_ack_i,
  input  logic                clk_fail_i,
  input  logic                ucl_ack_i,
  input  logic                ucl_fail_i,
  output logic [NUM_PART-1:0] part_rst_o,
  output logic [NUM_PART-1:0] pwr_req_o,
  output logic [NUM_PART-1:0] clk_en_o,
  output logic [NUM_PART-1:0] unclamp_o,
  output logic                done_o,
  output logic                err_o
);

  localparam int MAXC = (SETTLE_CYC > HS_TIMEOUT) ? SETTLE_CYC : HS_TIMEOUT;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0]   cnt;
  logic            cnt_clr;
  pps_cmd_t        cmd;
  logic [IDXW-1:0] idx;

  pps_cycle_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  pps_fsm #(
    .NUM_PART   (NUM_PART),
    .IDXW       (IDXW),
    .SETTLE_CYC (SETTLE_CYC),
    .HS_TIMEOUT (HS_TIMEOUT),
    .CW         (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .part_idx_i  (part_idx_i),
    .pwr_state_i (pwr_state_i),
    .pwr_ack_i   (pwr_ack_i),
    .pwr_fail_i  (pwr_fail_i),
    .clk_ack_i   (clk_ack_i),
    .clk_fail_i  (clk_fail_i),
    .ucl_ack_i   (ucl_ack_i),
    .ucl_fail_i  (ucl_fail_i),
    .cnt_i       (cnt),
    .clr_o       (cnt_clr),
    .cmd_o       (cmd),
    .idx_o       (idx),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  pps_flag_bank #(.N(NUM_PART), .IW(IDXW), .RST_VAL(1'b1)) u_rst_bank (
    .clk (clk), .rst_n (rst_n), .idx_i (idx),
    .set_i (cmd.rst_set), .clr_i (cmd.rst_clr), .q_o (part_rst_o)
  );

  pps_flag_bank #(.N(NUM_PART), .IW(IDXW), .RST_VAL(1'b0)) u_pwr_bank (
    .clk (clk), .rst_n (rst_n), .idx_i (idx),
    .set_i (cmd.pwr_set), .clr_i (cmd.pwr_clr), .q_o (pwr_req_o)
  );

  pps_flag_bank #(.N(NUM_PART), .IW(IDXW), .RST_VAL(1'b0)) u_clk_bank (
    .clk (clk), .rst_n (rst_n), .idx_i (idx),
    .set_i (cmd.clk_set), .clr_i (cmd.clk_clr), .q_o (clk_en_o)
  );

  pps_flag_bank #(.N(NUM_PART), .IW(IDXW), .RST_VAL(1'b0)) u_ucl_bank (
    .clk (clk), .rst_n (rst_n), .idx_i (idx),
    .set_i (cmd.ucl_set), .clr_i (cmd.ucl_clr), .q_o (unclamp_o)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int NUM_PART = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done_o,
  input logic                err_o,
  input logic [NUM_PART-1:0] part_rst_o,
  input logic [NUM_PART-1:0] clk_en_o,
  input logic [NUM_PART-1:0] unclamp_o
);

  // R12
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R3
  unclamp_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unclamp_o & ~clk_en_o) == '0);

  // R5
  release_needs_unclamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~part_rst_o & ~unclamp_o) == '0);

endmodule

bind partition_powerup_seq pps_checker #(.NUM_PART(NUM_PART)) u_pps_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_o     (done_o),
  .err_o      (err_o),
  .part_rst_o (part_rst_o),
  .clk_en_o   (clk_en_o),
  .unclamp_o  (unclamp_o)
);

// File: tb/tb_partition_powerup_seq.sv
module tb_partition_powerup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int S  = 12;
  localparam int T  = 20;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [IW-1:0] part_idx_i = '0;
  logic [NP-1:0] pwr_state_i = 8'b0010_0000;
  logic          pwr_ack_i = 1'b0, pwr_fail_i = 1'b0;
  logic          clk_ack_i = 1'b0, clk_fail_i = 1'b0;
  logic          ucl_ack_i = 1'b0, ucl_fail_i = 1'b0;
  logic [NP-1:0] part_rst_o, pwr_req_o, clk_en_o, unclamp_o;
  logic          done_o, err_o;

  partition_powerup_seq #(.NUM_PART(NP), .SETTLE_CYC(S), .HS_TIMEOUT(T)) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .part_idx_i (part_idx_i),
    .pwr_state_i (pwr_state_i),
    .pwr_ack_i (pwr_ack_i), .pwr_fail_i (pwr_fail_i),
    .clk_ack_i (clk_ack_i), .clk_fail_i (clk_fail_i),
    .ucl_ack_i (ucl_ack_i), .ucl_fail_i (ucl_fail_i),
    .part_rst_o (part_rst_o), .pwr_req_o (pwr_req_o),
    .clk_en_o (clk_en_o), .unclamp_o (unclamp_o),
    .done_o (done_o), .err_o (err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit            is_done;
    int            due;
    logic [NP-1:0] rst_v, pwr_v, clk_v, ucl_v;
    string         req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  logic [NP-1:0] m_rst = '1, m_pwr = '0, m_clk = '0, m_ucl = '0;
  logic [NP-1:0] p_rst = '1, p_pwr = '0, p_clk = '0;
  bit   pulse_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NP; i++) begin
        if (pwr_req_o[i] && !p_pwr[i])
          chk(p_rst[i], "R2", "reset held before power request", p_rst[i], 1);
        if (clk_en_o[i] && !p_clk[i])
          chk((p_pwr[i] | pwr_state_i[i]) && !unclamp_o[i], "R3",
              "clock rose without power or with clamp open", p_pwr[i], 1);
      end
      if (pulse_seen) begin
        chk(!done_o && !err_o, "R12", "strobe longer than one cycle", {done_o, err_o}, 0);
        pulse_seen = 0;
      end else if (done_o || err_o) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected result strobe", {done_o, err_o}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(done_o == e.is_done && err_o == !e.is_done, e.req, "strobe kind",
              {done_o, err_o}, {e.is_done, !e.is_done});
          chk(cyc == e.due, e.req, "result edge", cyc, e.due);
          chk({part_rst_o, pwr_req_o, clk_en_o, unclamp_o} ==
              {e.rst_v, e.pwr_v, e.clk_v, e.ucl_v}, e.req, "partition outputs",
              {part_rst_o, pwr_req_o, clk_en_o, unclamp_o},
              {e.rst_v, e.pwr_v, e.clk_v, e.ucl_v});
        end
        pulse_seen = 1;
      end
      p_rst = part_rst_o; p_pwr = pwr_req_o; p_clk = clk_en_o;
    end
  end

  // kind: 0 success, 1 power fault, 2 clock fault, 3 clamp fault
  task automatic run(int idx, bit pa, bit pf, bit ca, bit cf, bit ua, bit uf,
                     int kind, int lat, string req, int ign_idx);
    exp_t e;
    @(negedge clk);
    pwr_ack_i = pa; pwr_fail_i = pf;
    clk_ack_i = ca; clk_fail_i = cf;
    ucl_ack_i = ua; ucl_fail_i = uf;
    case (kind)
      0: begin
        m_rst[idx] = 1'b0; m_clk[idx] = 1'b1; m_ucl[idx] = 1'b1;
        if (!pwr_state_i[idx]) m_pwr[idx] = 1'b1;
      end
      1: begin m_rst[idx] = 1'b1; m_pwr[idx] = 1'b0; m_ucl[idx] = 1'b0; end
      default: begin
        m_rst[idx] = 1'b1; m_pwr[idx] = 1'b0; m_clk[idx] = 1'b0; m_ucl[idx] = 1'b0;
      end
    endcase
    e.is_done = (kind == 0);
    e.due = cyc + 1 + lat;
    e.rst_v = m_rst; e.pwr_v = m_pwr; e.clk_v = m_clk; e.ucl_v = m_ucl;
    e.req = req;
    q.push_back(e);
    start_i = 1'b1; part_idx_i = IW'(idx);
    @(negedge clk);
    start_i = 1'b0;
    if (ign_idx >= 0) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; part_idx_i = IW'(ign_idx);
      @(negedge clk);
      start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({part_rst_o, pwr_req_o, clk_en_o, unclamp_o, done_o, err_o} ==
        {{NP{1'b1}}, {3*NP{1'b0}}, 2'b00}, "R1", "reset state",
        {part_rst_o, pwr_req_o, clk_en_o, unclamp_o, done_o, err_o},
        {{NP{1'b1}}, {3*NP{1'b0}}, 2'b00});

    // R4 R5 plain success
    run(0, 1,0, 1,0, 1,0, 0, 5+2*S, "R4 R5", -1);
    // R11 start on partition 0 during a running sequence is ignored
    run(1, 1,0, 1,0, 1,0, 0, 5+2*S, "R11", 0);
    // R6 partition 5 already powered
    run(5, 1,0, 1,0, 1,0, 0, 4+2*S, "R6", -1);
    // R7 power failure, and R12 failure beats acknowledge
    run(2, 1,1, 1,0, 1,0, 1, 3, "R7", -1);
    // R10 power timeout
    run(3, 0,0, 1,0, 1,0, 1, 2+T, "R10", -1);
    // R8 clock failure
    run(4, 1,0, 0,1, 1,0, 2, 5, "R8", -1);
    // R10 clock timeout
    run(6, 1,0, 0,0, 1,0, 2, 4+T, "R10", -1);
    // R9 clamp failure
    run(7, 1,0, 1,0, 0,1, 3, 7+S, "R9", -1);
    // R10 clamp timeout
    run(2, 1,0, 1,0, 0,0, 3, 6+S+T, "R10", -1);
    // R4 recovery after faults
    run(2, 1,0, 1,0, 1,0, 0, 5+2*S, "R4", -1);
    // R9 clamp failure on a partition that was already running
    run(0, 1,0, 1,0, 0,1, 3, 7+S, "R9", -1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule